// File: doc/BRIEF.md
# EDO Page-Mode Access Sequencer

This block drives the strobes and the multiplexed address of an asynchronous DRAM that has an extended-data-out page mode. A host presents one column transfer at a time: row, column, direction and write data. It holds the request until the block returns a one-cycle acknowledge. The block opens the row by dropping RAS. It then runs column cycles for as long as the host keeps asking for the same row. It closes the row when the host goes idle, when the host moves to another row, or when one more column would push the RAS-low time past its ceiling. In the last case the row is precharged and reopened, and the burst continues with the next column.

Every timing figure is a nanosecond parameter. The block converts each figure to clock cycles from the clock-period parameter. Minimums round up and the RAS-low ceiling rounds down. Read data is taken while CAS is already high again, inside the window in which an EDO part keeps its output valid. The data goes to the host in the same cycle as the acknowledge.

The controller has eight states. IDLE goes to ACTIVATE on a request. ACTIVATE goes to COL_SETUP when the row-to-column delay ends. COL_SETUP always goes to CAS_LOW after one cycle. CAS_LOW goes to CAS_HIGH when the pulse width ends. CAS_HIGH goes to DECIDE when the high phase ends, and this is the acknowledge cycle. DECIDE goes back to COL_SETUP for a same-row request that still fits, and otherwise to ROW_HOLD. ROW_HOLD goes to PRECHARGE once both the hold-after-CAS time and the RAS-low minimum are met. PRECHARGE goes to IDLE when the precharge time ends.

Top module: `edo_page_seq`

## Requirements
- R1: After reset, RAS, CAS and WE are high (inactive), the data output enable is low and the acknowledge is low.
- R2: A row opens with RAS falling while the address carries the request row. CAS falls no sooner than the row-to-column delay (4 cycles at 5 ns), and the address then carries the request column. CAS is low only while RAS is low.
- R3: Every CAS-low pulse lasts at least the pulse-width minimum rounded up to cycles (10 ns gives 2 cycles at 5 ns).
- R4: Successive CAS falling edges within one RAS-low period are at least the page-cycle minimum apart (25 ns gives 5 cycles).
- R5: For a write (request direction bit = 1), WE is already low in the cycle before CAS falls and stays low through the whole CAS-low pulse. The output enable is high and the data output equals the request data when CAS falls.
- R6: For a read (direction bit = 0), the data returned with the acknowledge is the word the DRAM drove in response to that CAS pulse, sampled after CAS has risen.
- R7: Each column transfer produces exactly one single-cycle acknowledge, and exactly one CAS pulse happens per acknowledge.
- R8: Consecutive requests to the same row are served without RAS rising between them, while the RAS-low ceiling allows.
- R9: RAS rises only after at least the hold-after-CAS-precharge time (10 ns gives 2 cycles) since CAS last rose, and only after RAS has been low for at least the RAS-low minimum (60 ns gives 12 cycles). A request for a different row closes the open row.
- R10: RAS is never low for more than the RAS-low ceiling rounded down to cycles. A same-row burst that would exceed the ceiling is split: the row is precharged, reopened and the remaining columns are served.
- R11: RAS stays high for at least the precharge time (40 ns gives 8 cycles) between two row openings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; held until acknowledged |
| req_row | input | AW | Row of the request |
| req_col | input | AW | Column of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-cycle transfer acknowledge |
| rd_data | output | DW | Read data, valid with req_ack on reads |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_out | output | DW | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DW | Data from the DRAM |

## Verification
The hardest case to reach is the split of a same-row burst at the RAS-low ceiling. At the default ceiling of 125 µs it would take thousands of column cycles. The bench therefore sets the ceiling to 400 ns, so that only six columns fit in one opening, and then issues a directed run of ten reads to one row. This forces a mid-burst precharge and reopen. It also keeps the random traffic on three rows so that long same-row runs happen often. The bench's DRAM model changes its output only when CAS falls, so a read that samples too early or too late returns a wrong word.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACT,
        S_COL,
        S_CASL,
        S_CASH,
        S_NEXT,
        S_HOLD,
        S_PRE
    } seq_state_t;

    // round a nanosecond figure up to whole clock cycles
    function automatic int ns2cyc_up(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_phase_timer.sv
`timescale 1ns/1ps
module edo_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R4
    timer_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);
endmodule

// File: rtl/edo_ras_window.sv
`timescale 1ns/1ps
module edo_ras_window #(
    parameter int CNT_W  = 16,
    parameter int RMAX_C = 100,
    parameter int RMIN_C = 12,
    parameter int NEED_C = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic fits,
    output logic min_met
);
    logic [CNT_W-1:0] low_cnt;
    logic [31:0]      low32;

    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= '0;
        else if (!ras_low)     low_cnt <= '0;
        else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end

    assign low32   = 32'(low_cnt);
    assign fits    = (low32 + 32'(NEED_C)) <= 32'(RMAX_C);
    assign min_met = (low32 + 32'd1) >= 32'(RMIN_C);

    // R10
    ras_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (low32 < 32'(RMAX_C)));
endmodule

// File: rtl/edo_page_seq.sv
`timescale 1ns/1ps
module edo_page_seq
    import edo_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 32,
    parameter int CLK_NS    = 5,
    parameter int CASW_NS   = 10,
    parameter int PCYC_NS   = 25,
    parameter int CPA_NS    = 35,
    parameter int RHCP_NS   = 10,
    parameter int RCD_NS    = 20,
    parameter int RP_NS     = 40,
    parameter int RASMIN_NS = 60,
    parameter int RASMAX_NS = 125000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_row,
    input  logic [AW-1:0] req_col,
    input  logic          req_we,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rd_data,
    output logic          dram_ras_n,
    output logic          dram_cas_n,
    output logic          dram_we_n,
    output logic [AW-1:0] dram_addr,
    output logic [DW-1:0] dram_dq_out,
    output logic          dram_dq_oe,
    input  logic [DW-1:0] dram_dq_in
);
    localparam int LO_C   = imax(1, ns2cyc_up(CASW_NS, CLK_NS));
    localparam int CYC_C  = ns2cyc_up(PCYC_NS, CLK_NS);
    localparam int CPA_C  = ns2cyc_up(CPA_NS, CLK_NS);
    localparam int HI_C   = imax(1, imax(CPA_C, CYC_C - LO_C - 2));
    localparam int RH_C   = imax(1, ns2cyc_up(RHCP_NS, CLK_NS));
    localparam int RCD_C  = imax(1, ns2cyc_up(RCD_NS, CLK_NS));
    localparam int RP_C   = imax(1, ns2cyc_up(RP_NS, CLK_NS));
    localparam int RMIN_C = ns2cyc_up(RASMIN_NS, CLK_NS);
    localparam int RMAX_C = RASMAX_NS / CLK_NS;
    localparam int NEED_C = 3 + LO_C + HI_C + RH_C;
    localparam int CNT_W  = $clog2(RMAX_C + HI_C + RP_C + RCD_C + 4);

    seq_state_t       state, nxt;
    logic [AW-1:0]    row_q;
    logic             t_load, t_done, fits, min_met;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] cas_run;

    edo_phase_timer #(.W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    edo_ras_window #(.CNT_W(CNT_W), .RMAX_C(RMAX_C), .RMIN_C(RMIN_C), .NEED_C(NEED_C)) i_rwin (
        .clk(clk), .rst_n(rst_n), .ras_low(!dram_ras_n), .fits(fits), .min_met(min_met)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid) nxt = S_ACT;
            S_ACT:  if (t_done) nxt = S_COL;
            S_COL:  nxt = S_CASL;
            S_CASL: if (t_done) nxt = S_CASH;
            S_CASH: if (t_done) nxt = S_NEXT;
            S_NEXT: nxt = (req_valid && req_row == row_q && fits) ? S_COL : S_HOLD;
            S_HOLD: if (t_done && min_met) nxt = S_PRE;
            S_PRE:  if (t_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // phase length loaded on every state change
    always_comb begin
        t_load = (nxt != state);
        unique case (nxt)
            S_ACT:   t_val = CNT_W'(RCD_C - 1);
            S_CASL:  t_val = CNT_W'(LO_C - 1);
            S_CASH:  t_val = CNT_W'(HI_C - 1);
            S_HOLD:  t_val = CNT_W'(RH_C - 1);
            S_PRE:   t_val = CNT_W'(RP_C - 1);
            default: t_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            row_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) row_q <= req_row;
        end
    end

    // strobe and bus decode
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_addr   = req_col;
        dram_dq_out = req_wdata;
        req_ack     = 1'b0;
        unique case (state)
            S_IDLE: dram_addr = req_row;
            S_ACT: begin
                dram_ras_n = 1'b0;
                dram_addr  = row_q;
            end
            S_COL: begin
                dram_ras_n = 1'b0;
                dram_we_n  = !req_we;
                dram_dq_oe = req_we;
            end
            S_CASL: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = !req_we;
                dram_dq_oe = req_we;
            end
            S_CASH: begin
                dram_ras_n = 1'b0;
                req_ack    = t_done;
            end
            S_NEXT, S_HOLD: dram_ras_n = 1'b0;
            S_PRE: dram_addr = row_q;
            default: ;
        endcase
    end

    assign rd_data = dram_dq_in;

    // low-pulse length tracker for the width check
    always_ff @(posedge clk) begin
        if (!rst_n)             cas_run <= '0;
        else if (dram_cas_n)    cas_run <= '0;
        else if (cas_run != '1) cas_run <= cas_run + 1'b1;
    end

    // R2
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    // R3
    cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> (32'(cas_run) >= 32'(LO_C)));
    // R5
    we_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_we_n));
    // R5
    we_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_we_n) |-> dram_cas_n);
    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    // R9
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> $past(min_met));
endmodule

// File: tb/test_edo_page_seq.sv
`timescale 1ns/1ps
module test_edo_page_seq;
    localparam int AW = 4, DW = 16, CLK_NS = 5, RMAX_NS = 400;

    function automatic int up(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    localparam int E_LO = up(10), E_CYC = up(25), E_RH = up(10), E_RCD = up(20);
    localparam int E_RP = up(40), E_RMIN = up(60), E_RMAX = RMAX_NS / CLK_NS;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_we = 0;
    logic [AW-1:0] req_row = 0, req_col = 0;
    logic [DW-1:0] req_wdata = 0, dq_in = 0;
    logic req_ack, ras_n, cas_n, we_n, dq_oe;
    logic [DW-1:0] rd_data, dq_out;
    logic [AW-1:0] addr;

    edo_page_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS), .RASMAX_NS(RMAX_NS)) i_edo_page_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
        .req_we(req_we), .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0, n_issued = 0, n_acks = 0, ras_falls = 0;
    logic [DW-1:0] dram_m [256];
    logic [DW-1:0] ref_m  [256];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // DRAM model and protocol monitor, sampled at the falling edge
    logic ras_p = 1, cas_p = 1, we_p = 1;
    int ras_len = 0, ras_hi = 1000, cas_len = 0, since_cas_f = 0, since_cas_r = 1000;
    int we_run = 0, falls_since_ack = 0;
    bit seen_cas = 0, cur_wr = 0;
    logic [AW-1:0] open_row = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_cas_f++; since_cas_r++;
            if (ras_p && !ras_n) begin
                chk(ras_hi >= E_RP, "R11 precharge", ras_hi, E_RP);
                chk(addr == req_row, "R2 row address", int'(addr), int'(req_row));
                open_row = addr; ras_len = 1; seen_cas = 0; ras_falls++;
            end else if (!ras_n) ras_len++;
            if (!ras_p && ras_n) begin
                chk(ras_len <= E_RMAX, "R10 ras ceiling", ras_len, E_RMAX);
                chk(ras_len >= E_RMIN, "R9 ras minimum", ras_len, E_RMIN);
                chk(since_cas_r >= E_RH, "R9 hold after cas", since_cas_r, E_RH);
                ras_hi = 1;
            end else if (ras_n) ras_hi++;
            if (cas_p && !cas_n) begin
                chk(!ras_n, "R2 cas inside ras", int'(ras_n), 0);
                chk(addr == req_col, "R2 column address", int'(addr), int'(req_col));
                chk(ras_len - 1 >= E_RCD, "R2 row to column", ras_len - 1, E_RCD);
                if (seen_cas) chk(since_cas_f >= E_CYC, "R4 page cycle", since_cas_f, E_CYC);
                seen_cas = 1; since_cas_f = 0; cas_len = 1; falls_since_ack++;
                cur_wr = !we_n;
                if (!we_n) begin
                    chk(!we_p, "R5 we before cas", int'(we_p), 0);
                    chk(dq_oe && dq_out == req_wdata, "R5 write data", int'(dq_out), int'(req_wdata));
                    dram_m[{open_row, addr}] = dq_out;
                end else dq_in <= dram_m[{open_row, addr}];
            end else if (!cas_n) cas_len++;
            if (!cas_p && cas_n) begin
                chk(cas_len >= E_LO, "R3 cas width", cas_len, E_LO);
                if (cur_wr) chk(we_run >= cas_len + 1, "R5 we through pulse", we_run, cas_len + 1);
                since_cas_r = 0;
            end
            we_run = we_n ? 0 : we_run + 1;
            if (req_ack) begin
                n_acks++;
                chk(falls_since_ack == 1, "R7 one pulse per ack", falls_since_ack, 1);
                falls_since_ack = 0;
                if (!req_we)
                    chk(rd_data == ref_m[{req_row, req_col}], "R6 read data",
                        int'(rd_data), int'(ref_m[{req_row, req_col}]));
            end
            ras_p = ras_n; cas_p = cas_n; we_p = we_n;
        end
    end

    task automatic xfer(input int row, input int col, input bit we, input int data);
        int guard;
        req_valid = 1; req_row = AW'(row); req_col = AW'(col); req_we = we; req_wdata = DW'(data);
        if (we) ref_m[{req_row, req_col}] = DW'(data);
        n_issued++;
        guard = 0;
        forever begin
            @(negedge clk);
            if (req_ack) break;
            guard++;
            if (guard > 500) begin
                chk(0, "R7 ack missing", 0, 1);
                break;
            end
        end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic settle();
        repeat (30) @(posedge clk);
        #1;
    endtask

    function automatic int fill(input int i);
        return (i * 4951 + 12345) & 16'hFFFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int rf0;
        void'($urandom(32'd7));
        for (int i = 0; i < 256; i++) begin
            dram_m[i] = DW'(fill(i));
            ref_m[i]  = DW'(fill(i));
        end
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);
        chk(!dq_oe && !req_ack, "R1 enable and ack low", int'({dq_oe, req_ack}), 0);
        @(posedge clk); #1;

        // R8: short same-row burst keeps the page open
        rf0 = ras_falls;
        xfer(5, 1, 1, 16'h1111);
        xfer(5, 2, 1, 16'h2222);
        xfer(5, 3, 0, 0);
        settle();
        chk(ras_falls - rf0 == 1, "R8 page kept open", ras_falls - rf0, 1);

        // R6: read back written words
        xfer(5, 1, 0, 0);
        xfer(5, 2, 0, 0);
        settle();

        // R9: row change closes the row
        rf0 = ras_falls;
        xfer(1, 7, 0, 0);
        xfer(2, 7, 0, 0);
        settle();
        chk(ras_falls - rf0 == 2, "R9 row change reopens", ras_falls - rf0, 2);

        // R10: long same-row burst is split at the ceiling
        rf0 = ras_falls;
        for (int c = 0; c < 10; c++) xfer(9, c, 0, 0);
        settle();
        chk(ras_falls - rf0 >= 2, "R10 burst split", ras_falls - rf0, 2);

        // random traffic on a few rows
        for (int k = 0; k < 300; k++) begin
            xfer(int'($urandom % 3), int'($urandom % 16), bit'($urandom % 2), int'($urandom & 16'hFFFF));
            if ($urandom % 5 == 0) begin
                repeat ($urandom % 20) @(posedge clk);
                #1;
            end
        end
        settle();
        chk(n_acks == n_issued, "R7 ack count", n_acks, n_issued);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule